// File: doc/BRIEF.md
# Partial Reconfiguration Load Engine

This block is the device side of a partial-reconfiguration loading path, as a host sees it through six 64-bit register slots. The host resets the engine through a request/acknowledge handshake. It then opens a load for one of four regions and pushes 32-bit image words into an internal queue. A status field shows the free queue space as credits. When the host flags the push as complete, the engine drains the queue toward a configuration sink over a valid/ready stream. Hardware drops the start request once the queue is empty, and that drop tells the host the load is finished.

Errors stay in a sticky vector until the host writes ones to the matching bits. The errors come from misuse by the host (a word written with no credit or outside a load, or a completion flag with no load open) and from the sink (checksum, incompatible image, secure-load failure). A fixed 128-bit interface identifier can be read so the host can choose a matching image format.

The sequencer has four states. ST_IDLE reports host state 0. ST_LOAD reports 1. ST_DRAIN reports 2. ST_RST reports 3.

Its transitions are:
- A control write with the reset bit set moves any state to ST_RST.
- In ST_RST, a control write with the reset bit clear moves to ST_IDLE.
- In ST_IDLE, a control write with start set and reset and push-complete clear moves to ST_LOAD.
- In ST_LOAD, a control write with push-complete set moves to ST_DRAIN.
- In ST_DRAIN, an empty queue moves to ST_IDLE.

Top module: `pr_csr_engine`

## Requirements
- R1: Register slots by index: 0 control, 1 status, 2 data (reads 0), 3 error, 4 identifier low half, 5 identifier high half. Slots 6 and 7 read 0. Reserved bits read 0. After reset the control and error slots read 0, the status slot shows full credit with the empty bit set, and the stream is idle.
- R2: A control write with bit 0 set makes bit 0 and the acknowledge bit 4 read 1 and the host-state field (status bits 27:24) read 3. Queued words are discarded one cycle later. A control write with bit 0 clear then returns both bits and the host state to 0.
- R3: In ST_IDLE, a control write with bit 12 set (bits 0 and 13 clear) starts a load. It latches the region from bits 9:8 and the image kind from bit 14 onto the stream side outputs. Bit 12 then reads 1 and the host state reads 1. Bits 63:32 are stored and read back on every control write.
- R4: Status bits 8:0 hold the credit count. It equals the queue depth after reset, drops by one per accepted data word and rises by one per word the sink takes.
- R5: Accepted words (the low 32 bits of a data write) leave on the stream in write order. Each one is held until it is accepted with valid and ready both high.
- R6: A control write with bit 13 set in ST_LOAD moves to host state 2 with bits 12 and 13 reading 1. Once the queue is empty, hardware clears both bits and the host state returns to 0.
- R7: A data write with credit 0 or outside ST_LOAD is dropped. It sets error bits 4 and 0, and status bit 16 then reads 1.
- R8: A control write with bit 13 set and bit 0 clear in ST_IDLE sets error bits 3 and 0 and starts no load.
- R9: A one-cycle pulse on the checksum, incompatibility or secure-load input sets error bit 1, 2 or 6 respectively, together with bit 0.
- R10: Error bits are cleared only by writing 1 to them in slot 3. A new error in the same cycle wins over the clear. Errors survive the engine reset handshake, and bit 5 always reads 0.
- R11: Slots 4 and 5 return the identifier parameters, and writes to them change nothing.
- R12: Status bit 20 reads queue empty, bit 21 queue full, and bit 22 stream stall (valid high while ready is low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_wr_idx | input | 3 | Slot index of the write |
| csr_wr_data | input | 64 | Write data |
| csr_rd_idx | input | 3 | Slot index of the read |
| csr_rd_data | output | 64 | Read data, combinational from the index |
| cfg_valid | output | 1 | Stream word valid |
| cfg_ready | input | 1 | Sink ready |
| cfg_word | output | 32 | Stream word |
| cfg_region | output | 2 | Region latched at load start |
| cfg_kind | output | 1 | Image kind latched at load start |
| sink_crc_err | input | 1 | Sink checksum error pulse |
| sink_incompat_err | input | 1 | Sink incompatible-image pulse |
| sink_auth_err | input | 1 | Sink secure-load error pulse |

## Verification
A register write takes effect at the clock edge that samples it. The read port is combinational, so state, control bits, credit and error bits can be read at the next falling edge. The bench drives every input at a falling edge and reads one half period after the sampling edge. Two effects need a second edge: the queue flush after the acknowledge appears, and the return to ST_DRAIN's exit once the last word has left. For those the bench waits one more falling edge before reading. Stream words are compared at a falling edge while ready is high, and each comparison covers the word that the next rising edge removes.

// File: rtl/pr_csr_pkg.sv
package pr_csr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_RST   = 2'd3
    } pr_state_e;

    localparam int IDX_W   = 3;
    localparam int CRED_W  = 9;
    localparam int ERR_W   = 7;
    localparam int WORD_W  = 32;

    localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_STAT  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_DATA  = 3'd2;
    localparam logic [IDX_W-1:0] IDX_ERR   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_ID_LO = 3'd4;
    localparam logic [IDX_W-1:0] IDX_ID_HI = 3'd5;

    localparam int C_RESET = 0;
    localparam int C_ACK   = 4;
    localparam int C_REG_L = 8;
    localparam int C_START = 12;
    localparam int C_PUSH  = 13;
    localparam int C_KIND  = 14;

    localparam int E_GEN   = 0;
    localparam int E_CRC   = 1;
    localparam int E_INC   = 2;
    localparam int E_PROTO = 3;
    localparam int E_OVF   = 4;
    localparam int E_AUTH  = 6;

    localparam logic [ERR_W-1:0] ERR_MASK = 7'b1011111;

endpackage

// File: rtl/pr_word_fifo.sv
module pr_word_fifo #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic do_push, do_pop;

    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // R7: the engine never offers a word to a full queue
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

// File: rtl/pr_err_vec.sv
module pr_err_vec
    import pr_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] set_vec,
    input  logic             clr_wr,
    input  logic [ERR_W-1:0] clr_vec,
    output logic [ERR_W-1:0] err
);
    logic [ERR_W-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_vec : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) err <= '0;
        else        err <= ((err & ~clr_eff) | set_vec) & ERR_MASK;
    end

    // R10: with no clear write, no latched bit is lost
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((err & $past(err)) == $past(err)));

    // R9: a sink pulse is latched on the next cycle
    p_sink_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[E_CRC] |=> err[E_CRC]);

endmodule

// File: rtl/pr_seq_fsm.sv
module pr_seq_fsm
    import pr_csr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_wr,
    input  logic      ctl_reset_bit,
    input  logic      ctl_start_bit,
    input  logic      ctl_push_bit,
    input  logic      fifo_empty,
    output pr_state_e state,
    output logic [3:0] host_state,
    output logic      start_req,
    output logic      push_done,
    output logic      reset_ack,
    output logic      flush,
    output logic      start_pulse,
    output logic      proto_err
);
    pr_state_e nxt;
    logic go_reset;

    assign go_reset    = ctl_wr && ctl_reset_bit;
    assign start_pulse = (state == ST_IDLE) && ctl_wr && ctl_start_bit
                         && !ctl_reset_bit && !ctl_push_bit;
    assign proto_err   = (state == ST_IDLE) && ctl_wr && ctl_push_bit
                         && !ctl_reset_bit;

    always_comb begin
        nxt = state;
        if (go_reset) begin
            nxt = ST_RST;
        end else begin
            unique case (state)
                ST_IDLE:  if (start_pulse) nxt = ST_LOAD;
                ST_LOAD:  if (ctl_wr && ctl_push_bit) nxt = ST_DRAIN;
                ST_DRAIN: if (fifo_empty) nxt = ST_IDLE;
                ST_RST:   if (ctl_wr) nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        host_state = 4'd0;
        start_req  = 1'b0;
        push_done  = 1'b0;
        reset_ack  = 1'b0;
        flush      = 1'b0;
        unique case (state)
            ST_IDLE:  host_state = 4'd0;
            ST_LOAD: begin
                host_state = 4'd1;
                start_req  = 1'b1;
            end
            ST_DRAIN: begin
                host_state = 4'd2;
                start_req  = 1'b1;
                push_done  = 1'b1;
            end
            ST_RST: begin
                host_state = 4'd3;
                reset_ack  = 1'b1;
                flush      = 1'b1;
            end
        endcase
    end

    // R2: a reset request always lands in the reset state
    p_reset_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go_reset |=> (state == ST_RST));

    // R6: draining with an empty queue releases the start request
    p_drain_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && fifo_empty && !go_reset) |=> (state == ST_IDLE));

endmodule

// File: rtl/pr_csr_engine.sv
module pr_csr_engine
    import pr_csr_pkg::*;
#(
    parameter int          FIFO_DEPTH = 256,
    parameter logic [63:0] IFC_ID_LO  = 64'h0123_4567_89AB_CDEF,
    parameter logic [63:0] IFC_ID_HI  = 64'hFEDC_BA98_7654_3210
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_wr,
    input  logic [2:0]  csr_wr_idx,
    input  logic [63:0] csr_wr_data,
    input  logic [2:0]  csr_rd_idx,
    output logic [63:0] csr_rd_data,
    output logic        cfg_valid,
    input  logic        cfg_ready,
    output logic [31:0] cfg_word,
    output logic [1:0]  cfg_region,
    output logic        cfg_kind,
    input  logic        sink_crc_err,
    input  logic        sink_incompat_err,
    input  logic        sink_auth_err
);
    localparam int CNT_W = $clog2(FIFO_DEPTH+1);

    pr_state_e         state;
    logic [3:0]        host_state;
    logic              start_req, push_done, reset_ack, flush;
    logic              start_pulse, proto_err;
    logic              ctl_wr, dat_wr, err_wr;
    logic              accept, drop, pop;
    logic              f_empty, f_full;
    logic [CNT_W-1:0]  f_count;
    logic [CRED_W-1:0] credit;
    logic [ERR_W-1:0]  err, set_vec;
    logic              reset_req;
    logic [31:0]       cfg_hi;
    logic [2:0]        ctl_stat;

    assign ctl_wr = csr_wr && (csr_wr_idx == IDX_CTRL);
    assign dat_wr = csr_wr && (csr_wr_idx == IDX_DATA);
    assign err_wr = csr_wr && (csr_wr_idx == IDX_ERR);

    pr_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_wr        (ctl_wr),
        .ctl_reset_bit (csr_wr_data[C_RESET]),
        .ctl_start_bit (csr_wr_data[C_START]),
        .ctl_push_bit  (csr_wr_data[C_PUSH]),
        .fifo_empty    (f_empty),
        .state         (state),
        .host_state    (host_state),
        .start_req     (start_req),
        .push_done     (push_done),
        .reset_ack     (reset_ack),
        .flush         (flush),
        .start_pulse   (start_pulse),
        .proto_err     (proto_err)
    );

    assign accept    = dat_wr && (state == ST_LOAD) && !f_full;
    assign drop      = dat_wr && !accept;
    assign cfg_valid = !f_empty;
    assign pop       = cfg_valid && cfg_ready;

    pr_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (accept),
        .push_data (csr_wr_data[WORD_W-1:0]),
        .pop       (pop),
        .head      (cfg_word),
        .empty     (f_empty),
        .full      (f_full),
        .count     (f_count)
    );

    assign credit = CRED_W'(FIFO_DEPTH) - CRED_W'(f_count);

    always_comb begin
        set_vec          = '0;
        set_vec[E_OVF]   = drop;
        set_vec[E_PROTO] = proto_err;
        set_vec[E_CRC]   = sink_crc_err;
        set_vec[E_INC]   = sink_incompat_err;
        set_vec[E_AUTH]  = sink_auth_err;
        set_vec[E_GEN]   = drop | proto_err | sink_crc_err
                           | sink_incompat_err | sink_auth_err;
    end

    pr_err_vec u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_wr  (err_wr),
        .clr_vec (csr_wr_data[ERR_W-1:0]),
        .err     (err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req  <= 1'b0;
            cfg_hi     <= '0;
            cfg_region <= '0;
            cfg_kind   <= 1'b0;
        end else begin
            if (ctl_wr) begin
                reset_req <= csr_wr_data[C_RESET];
                cfg_hi    <= csr_wr_data[63:32];
            end
            if (start_pulse) begin
                cfg_region <= csr_wr_data[C_REG_L+1:C_REG_L];
                cfg_kind   <= csr_wr_data[C_KIND];
            end
        end
    end

    assign ctl_stat = {cfg_valid && !cfg_ready, f_full, f_empty};

    always_comb begin
        csr_rd_data = '0;
        unique case (csr_rd_idx)
            IDX_CTRL:  csr_rd_data = {cfg_hi, 17'd0, cfg_kind, push_done, start_req,
                                      2'd0, cfg_region, 3'd0, reset_ack, 3'd0, reset_req};
            IDX_STAT:  csr_rd_data = {36'd0, host_state, 1'b0, ctl_stat, 3'd0,
                                      |err, 7'd0, credit};
            IDX_ERR:   csr_rd_data = {57'd0, err};
            IDX_ID_LO: csr_rd_data = IFC_ID_LO;
            IDX_ID_HI: csr_rd_data = IFC_ID_HI;
            default:   csr_rd_data = '0;
        endcase
    end

    // R4: an accepted word with no drain costs exactly one credit
    p_credit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pop && !flush) |=> (credit == $past(credit) - 1'b1));

    // R7: a dropped word is always reported
    p_drop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (err[E_OVF] && err[E_GEN]));

endmodule

// File: tb/tb_pr_csr_engine.sv
module tb_pr_csr_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 256;
    localparam logic [63:0] IDL = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] IDH = 64'hFEDC_BA98_7654_3210;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [2:0]  csr_wr_idx = '0;
    logic [63:0] csr_wr_data = '0;
    logic [2:0]  csr_rd_idx = '0;
    logic [63:0] csr_rd_data;
    logic        cfg_valid;
    logic        cfg_ready = 1'b0;
    logic [31:0] cfg_word;
    logic [1:0]  cfg_region;
    logic        cfg_kind;
    logic        sink_crc_err = 1'b0;
    logic        sink_incompat_err = 1'b0;
    logic        sink_auth_err = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pr_csr_engine #(.FIFO_DEPTH(DEPTH), .IFC_ID_LO(IDL), .IFC_ID_HI(IDH)) dut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wr_idx(csr_wr_idx),
        .csr_wr_data(csr_wr_data), .csr_rd_idx(csr_rd_idx), .csr_rd_data(csr_rd_data),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_word(cfg_word),
        .cfg_region(cfg_region), .cfg_kind(cfg_kind), .sink_crc_err(sink_crc_err),
        .sink_incompat_err(sink_incompat_err), .sink_auth_err(sink_auth_err)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FIFO-ENGINE FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [63:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_wr_idx = idx; csr_wr_data = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [63:0] v);
        csr_rd_idx = idx;
        #1;
        v = csr_rd_data;
    endtask

    function automatic logic [63:0] stat_exp(input int cred, input int host,
                                             input bit stall, input bit full,
                                             input bit empty, input bit op);
        return (64'(host) << 24) | (64'(stall) << 22) | (64'(full) << 21)
             | (64'(empty) << 20) | (64'(op) << 16) | 64'(cred);
    endfunction

    task automatic t_reset_state();
        logic [63:0] v;
        rd(3'd0, v); chk("R1 control after reset", v, 64'd0);
        rd(3'd1, v); chk("R1 R4 status after reset", v, stat_exp(DEPTH, 0, 0, 0, 1, 0));
        rd(3'd3, v); chk("R1 error after reset", v, 64'd0);
        rd(3'd2, v); chk("R1 data slot reads zero", v, 64'd0);
        chk("R1 stream idle", {63'd0, cfg_valid}, 64'd0);
    endtask

    task automatic t_ident();
        logic [63:0] v;
        rd(3'd4, v); chk("R11 id low", v, IDL);
        rd(3'd5, v); chk("R11 id high", v, IDH);
        wr(3'd4, 64'hDEAD); wr(3'd5, 64'hBEEF);
        rd(3'd4, v); chk("R11 id low after write", v, IDL);
        rd(3'd5, v); chk("R11 id high after write", v, IDH);
        rd(3'd6, v); chk("R1 unused slot", v, 64'd0);
    endtask

    task automatic t_reset_hs();
        logic [63:0] v;
        cfg_ready = 1'b0;
        wr(3'd0, 64'h1000);
        wr(3'd2, 64'h55);
        wr(3'd0, 64'h1001);
        rd(3'd0, v); chk("R2 reset and ack bits", v, 64'h11);
        rd(3'd1, v); chk("R2 host state in reset", v >> 24 & 64'hF, 64'd3);
        @(negedge clk);
        rd(3'd1, v); chk("R2 queue flushed", v, stat_exp(DEPTH, 3, 0, 0, 1, 0));
        wr(3'd0, 64'h0);
        rd(3'd0, v); chk("R2 ack released", v, 64'd0);
        rd(3'd1, v); chk("R2 host idle", v >> 24 & 64'hF, 64'd0);
    endtask

    task automatic t_load();
        logic [63:0] v;
        logic [63:0] c;
        cfg_ready = 1'b0;
        c = (64'h0000_ABCD << 32) | (64'd1 << 14) | (64'd1 << 12) | (64'd2 << 8);
        wr(3'd0, c);
        rd(3'd0, v); chk("R3 control readback", v, c);
        rd(3'd1, v); chk("R3 host loading", v >> 24 & 64'hF, 64'd1);
        chk("R3 region and kind", {61'd0, cfg_region, cfg_kind}, 64'd5);
        for (int i = 0; i < 3; i++) wr(3'd2, (64'hFFFF_FFFF << 32) | 64'(32'hA0 + i));
        rd(3'd1, v); chk("R4 R12 credit after pushes", v, stat_exp(DEPTH-3, 1, 1, 0, 0, 0));
        chk("R5 first word waiting", {32'd0, cfg_word}, 64'hA0);
        cfg_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            chk("R5 stream order", {31'd0, cfg_valid, cfg_word}, {31'd0, 1'b1, 32'hA0 + 32'(i)});
            @(negedge clk);
        end
        chk("R5 stream empty", {63'd0, cfg_valid}, 64'd0);
        rd(3'd1, v); chk("R4 credit restored", v & 64'h1FF, 64'(DEPTH));
        cfg_ready = 1'b0;
        wr(3'd2, 64'hB0);
        wr(3'd0, c | (64'd1 << 13));
        rd(3'd1, v); chk("R6 host draining", v >> 24 & 64'hF, 64'd2);
        rd(3'd0, v); chk("R6 start and push set", v >> 12 & 64'h3, 64'h3);
        @(negedge clk);
        rd(3'd1, v); chk("R6 held while sink stalls", v >> 24 & 64'hF, 64'd2);
        cfg_ready = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(3'd0, v); chk("R6 start released", v >> 12 & 64'h3, 64'h0);
        rd(3'd1, v); chk("R6 host idle after drain", v, stat_exp(DEPTH, 0, 0, 0, 1, 0));
        cfg_ready = 1'b0;
    endtask

    task automatic t_overflow();
        logic [63:0] v;
        int n;
        logic [31:0] last;
        wr(3'd2, 64'h77);
        rd(3'd3, v); chk("R7 drop outside load", v, 64'h11);
        rd(3'd1, v); chk("R7 op error flag", v >> 16 & 64'h1, 64'd1);
        chk("R7 dropped word not sent", {63'd0, cfg_valid}, 64'd0);
        wr(3'd3, 64'h10);
        rd(3'd3, v); chk("R10 partial clear", v, 64'h01);
        wr(3'd3, 64'h01);
        rd(3'd3, v); chk("R10 full clear", v, 64'h00);
        cfg_ready = 1'b0;
        wr(3'd0, 64'h1000);
        for (int i = 0; i < DEPTH; i++) wr(3'd2, 64'(32'h1000_0000 + i));
        rd(3'd1, v); chk("R4 R12 credit zero and full", v, stat_exp(0, 1, 1, 1, 0, 0));
        wr(3'd2, 64'hCAFE);
        rd(3'd3, v); chk("R7 drop with no credit", v, 64'h11);
        cfg_ready = 1'b1;
        n = 0; last = '0;
        while (cfg_valid) begin
            last = cfg_word;
            n++;
            @(negedge clk);
        end
        chk("R7 word count after drop", 64'(n), 64'(DEPTH));
        chk("R5 last word kept", {32'd0, last}, 64'(32'h1000_0000 + DEPTH - 1));
        wr(3'd0, 64'h3000);
        @(negedge clk);
        rd(3'd1, v); chk("R6 idle after full load", v >> 24 & 64'hF, 64'd0);
        wr(3'd3, 64'h7F);
        cfg_ready = 1'b0;
    endtask

    task automatic t_protocol();
        logic [63:0] v;
        wr(3'd0, 64'h2000);
        rd(3'd3, v); chk("R8 push complete while idle", v, 64'h09);
        rd(3'd1, v); chk("R8 no load started", v >> 24 & 64'hF, 64'd0);
        wr(3'd3, 64'h09);
    endtask

    task automatic t_sink();
        logic [63:0] v;
        @(negedge clk); sink_crc_err = 1'b1;
        @(negedge clk); sink_crc_err = 1'b0;
        rd(3'd3, v); chk("R9 checksum error", v, 64'h03);
        sink_incompat_err = 1'b1; sink_auth_err = 1'b1;
        @(negedge clk); sink_incompat_err = 1'b0; sink_auth_err = 1'b0;
        rd(3'd3, v); chk("R9 incompat and secure-load", v, 64'h47);
        wr(3'd0, 64'h1); wr(3'd0, 64'h0);
        rd(3'd3, v); chk("R10 errors survive engine reset", v, 64'h47);
        @(negedge clk);
        sink_crc_err = 1'b1; csr_wr = 1'b1; csr_wr_idx = 3'd3; csr_wr_data = 64'h02;
        @(negedge clk);
        sink_crc_err = 1'b0; csr_wr = 1'b0; csr_wr_data = '0;
        rd(3'd3, v); chk("R10 set wins over clear", v, 64'h47);
        wr(3'd3, 64'h7F);
        rd(3'd3, v); chk("R10 bit5 never set, all cleared", v, 64'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FIFO-ENGINE FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_ident();
        t_reset_hs();
        t_load();
        t_overflow();
        t_protocol();
        t_sink();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule